// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a simple clocked request port and an asynchronous static RAM. The RAM has a 15-bit address, an 8-bit bidirectional data bus and three active-low strobes: chip enable, output enable and write enable. The block accepts one read or write at a time. It drives the address first and lowers the strobes in a fixed order. It holds them for a set number of clock cycles, releases them, and then reports completion with a one-cycle pulse. Every interval is a clock-cycle count set by a parameter: address setup, data turnaround, write pulse, output-enable delay, access time and hold.

A write can be ended in three ways: chip enable rises first, write enable rises first, or both rise in the same cycle. A read can lower output enable together with chip enable, or it can lower output enable a set number of cycles after chip enable. The data bus is split into an output value, an output enable and an input value. The pad-level tri-state sits outside the block.

Top module: `async_sram_ctrl`

## Requirements
- R1: Out of reset and whenever `busy` is low, all three strobes are high, `mem_addr` is zero, `mem_dq_oe` is low, and `done` is low except during its completion pulse.
- R2: When a request is accepted, its address is presented with all strobes high for SETUP_CYC cycles before any strobe falls. The address then stays constant while any strobe is low.
- R3: During a write, output enable stays high and chip and write enable fall in the same cycle. Both stay low for PULSE_CYC cycles. `mem_dq_oe` rises only after TURN_CYC of those cycles have passed.
- R4: `req_mode` selects how a write ends. With 0, chip enable rises first and write enable follows one cycle later. With 1, write enable rises first and chip enable follows one cycle later. With 2 or 3, both rise in the same cycle. Write data stays driven through that ending cycle.
- R5: The byte on `mem_dq_out` at the moment the write strobes stop overlapping is the request's write data, so a later read of that address returns it.
- R6: A read with `req_mode[0]`=0 lowers chip and output enable together and keeps write enable high. It holds them for ACCESS_CYC cycles and captures `mem_dq_in` into `rd_data` on the last of those cycles.
- R7: A read with `req_mode[0]`=1 lowers chip enable first and output enable OE_DLY_CYC cycles later. It then holds both for ACCESS_CYC cycles before capturing.
- R8: `mem_dq_oe` is never high while output enable is low, and it is never high at any point of a read.
- R9: After the strobes rise, all strobes stay high with the address unchanged for HOLD_CYC cycles before the block returns to idle.
- R10: `done` is a one-cycle pulse in the first idle cycle. Counted from the first busy cycle, it comes SETUP_CYC+PULSE_CYC+1+HOLD_CYC cycles later for a write, SETUP_CYC+ACCESS_CYC+HOLD_CYC for a plain read, and SETUP_CYC+OE_DLY_CYC+ACCESS_CYC+HOLD_CYC for a delayed read.
- R11: A request presented while `busy` is high is ignored and does not change the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Write ending style, or read output-enable delay select in bit 0 |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_in | input | DATA_W | Data returned from the RAM |

## Verification
The hardest case to reach is a request that lands in the middle of a transaction. It must leave both the running access and the stored contents untouched. The driver injects a write to an already written address a few cycles after a long write has started. It then reads both addresses back, and it also checks that the running write's latency and strobe shape are unchanged. A bench RAM model commits data only at the cycle where the write strobes stop overlapping, and it drives read data only while chip and output enable are both low. A wrong ending order or early capture therefore shows up as wrong data.

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int TURN_CYC   = 5,
  parameter int PULSE_CYC  = 10,
  parameter int OE_DLY_CYC = 7,
  parameter int ACCESS_CYC = 12,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int LONGEST = SETUP_CYC + PULSE_CYC + OE_DLY_CYC + ACCESS_CYC + HOLD_CYC + 2;
  localparam int CW      = $clog2(LONGEST + 1);

  localparam logic [CW-1:0] SETUP_LAST  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST  = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] ACC_LAST    = CW'(ACCESS_CYC - 1);
  localparam logic [CW-1:0] DLYACC_LAST = CW'(OE_DLY_CYC + ACCESS_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] TURN_V      = CW'(TURN_CYC);
  localparam logic [CW-1:0] OE_DLY_V    = CW'(OE_DLY_CYC);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACT, S_TERM, S_HOLD} phase_t;

  phase_t            state;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     act_last;
  logic              phase_last;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;
  logic [1:0]        mode_q;
  logic              wr_q;
  logic              done_q;

  wire end_by_ce = (mode_q == 2'd0);
  wire end_by_we = (mode_q == 2'd1);
  wire in_act    = (state == S_ACT);
  wire in_term   = (state == S_TERM);

  initial begin
    assert (SETUP_CYC >= 1 && HOLD_CYC >= 1 && ACCESS_CYC >= 1);
    assert (TURN_CYC >= 1 && TURN_CYC < PULSE_CYC);
  end

  assign act_last = wr_q ? PULSE_LAST : (mode_q[0] ? DLYACC_LAST : ACC_LAST);

  always_comb begin
    case (state)
      S_SETUP: phase_last = (cnt == SETUP_LAST);
      S_ACT:   phase_last = (cnt == act_last);
      S_TERM:  phase_last = 1'b1;
      S_HOLD:  phase_last = (cnt == HOLD_LAST);
      default: phase_last = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
      mode_q  <= 2'd0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state == S_IDLE) begin
        if (req_valid) begin
          state   <= S_SETUP;
          cnt     <= '0;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          mode_q  <= req_mode;
          wr_q    <= req_write;
        end
      end else if (phase_last) begin
        cnt <= '0;
        case (state)
          S_SETUP: state <= S_ACT;
          S_ACT:   state <= wr_q ? S_TERM : S_HOLD;
          S_TERM:  state <= S_HOLD;
          default: begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end
        endcase
        if (in_act && !wr_q) rd_q <= mem_dq_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy       = (state != S_IDLE);
  assign done       = done_q;
  assign rd_data    = rd_q;
  assign mem_addr   = busy ? addr_q : '0;
  assign mem_ce_n   = !(in_act || (in_term && end_by_we));
  assign mem_we_n   = !(wr_q && (in_act || (in_term && end_by_ce)));
  assign mem_oe_n   = !(!wr_q && in_act && (!mode_q[0] || cnt >= OE_DLY_V));
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = wr_q && ((in_act && cnt >= TURN_V) || in_term);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && mem_addr == '0)); // R1
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n || !mem_we_n || !mem_oe_n) |-> $stable(mem_addr)); // R2
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> ($past(mem_we_n) && $past(mem_oe_n) && $past(busy))); // R2
  AST_WR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($fell(mem_ce_n) && mem_oe_n)); // R3
  AST_DATA_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q) && $stable(wdata_q)); // R11

endmodule

// File: tb/async_sram_ctrl_tb.sv
module async_sram_ctrl_tb;
  localparam int SETUP = 1, TURN = 5, PULSE = 10, OED = 7, ACC = 12, HOLD = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done;
  logic [7:0]  rd_data;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hFF;

  always #5 clk = ~clk;

  async_sram_ctrl #(.ADDR_W(15), .DATA_W(8), .SETUP_CYC(SETUP), .TURN_CYC(TURN),
    .PULSE_CYC(PULSE), .OE_DLY_CYC(OED), .ACCESS_CYC(ACC), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  typedef struct { bit wr; logic [1:0] mode; logic [7:0] data; int lat; string tag; } exp_t;
  exp_t sbq[$];
  logic [7:0] ram [int];
  logic [7:0] shadow [int];
  int vectors = 0, miscompares = 0;
  int v_idle = 0, v_hold = 0, v_setup = 0, v_stable = 0, v_contend = 0, v_data = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int cyc = 0, start = 0, both_low = 0, nodata = 0, ce_only = 0, dq_cnt = 0, term = 3;
  logic [14:0] p_addr = '0;
  logic [7:0]  p_dq_out = '0;
  bit p_all_high = 1, p_both = 0, p_dq_oe = 0, p_busy = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit all_high, both;
      exp_t e;
      cyc++;
      all_high = mem_ce_n && mem_oe_n && mem_we_n;
      both = !mem_ce_n && !mem_we_n;
      if (!busy && (!all_high || mem_addr != '0 || mem_dq_oe)) v_idle++;
      if (mem_addr != p_addr && !(all_high && p_all_high)) v_hold++;
      if (!all_high && p_all_high && mem_addr != p_addr) v_setup++;
      if (!all_high && !p_all_high && mem_addr != p_addr) v_stable++;
      if (!mem_oe_n && mem_dq_oe) v_contend++;
      if (busy && !p_busy) begin
        start = cyc; both_low = 0; nodata = 0; ce_only = 0; dq_cnt = 0; term = 3;
      end
      if (both) both_low++;
      if (both && !mem_dq_oe) nodata++;
      if (!mem_ce_n && mem_oe_n && mem_we_n) ce_only++;
      if (mem_dq_oe) dq_cnt++;
      if (p_both && !both) begin
        term = (mem_ce_n && !mem_we_n) ? 0 : (!mem_ce_n && mem_we_n) ? 1 : 2;
        if (!p_dq_oe) v_data++;
        ram[int'(p_addr)] = p_dq_out;
      end
      mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n && ram.exists(int'(mem_addr)))
                  ? ram[int'(mem_addr)] : 8'hFF;
      if (done) begin
        if (sbq.size() == 0) check(0, "R10 unexpected done", 1, 0);
        else begin
          e = sbq.pop_front();
          check(cyc - start == e.lat, {"R10 latency ", e.tag}, cyc - start, e.lat);
          if (e.wr) begin
            check(term == (e.mode == 2'd0 ? 0 : e.mode == 2'd1 ? 1 : 2), {"R4 ending ", e.tag},
                  term, e.mode == 2'd0 ? 0 : e.mode == 2'd1 ? 1 : 2);
            check(nodata == TURN, {"R3 turnaround ", e.tag}, nodata, TURN);
            check(both_low == PULSE, {"R3 pulse ", e.tag}, both_low, PULSE);
          end else begin
            check(rd_data == e.data, {"read data ", e.tag}, rd_data, e.data);
            check(ce_only == (e.mode[0] ? OED : 0), {"R7 oe delay ", e.tag},
                  ce_only, e.mode[0] ? OED : 0);
            check(dq_cnt == 0, {"R8 read drive ", e.tag}, dq_cnt, 0);
          end
        end
      end
      p_addr = mem_addr; p_dq_out = mem_dq_out; p_all_high = all_high;
      p_both = both; p_dq_oe = mem_dq_oe; p_busy = busy;
    end
  end

  task automatic req(input bit wr, input logic [1:0] mode, input logic [14:0] addr,
                     input logic [7:0] data, input string tag, input bit inject = 0,
                     input logic [14:0] iaddr = '0, input logic [7:0] idata = '0);
    exp_t e;
    e.wr = wr; e.mode = mode; e.tag = tag;
    e.data = (!wr && shadow.exists(int'(addr))) ? shadow[int'(addr)] : 8'hFF;
    e.lat = wr ? SETUP + PULSE + 1 + HOLD : SETUP + (mode[0] ? OED : 0) + ACC + HOLD;
    if (wr) shadow[int'(addr)] = data;
    sbq.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mode = mode; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_mode = 2'd2; req_addr = iaddr; req_wdata = idata;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 reset strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(mem_addr == '0 && !mem_dq_oe, "R1 reset bus", int'(mem_addr), 0);
    check(!busy && !done, "R1 reset handshake", {busy, done}, 0);

    req(1, 2'd0, 15'd1, 8'h01, "R5 ce-ended write");
    req(1, 2'd1, 15'd2, 8'h02, "R5 we-ended write");
    req(0, 2'd0, 15'd1, 8'h00, "R6 plain read a1");
    req(0, 2'd0, 15'd2, 8'h00, "R6 plain read a2");
    req(1, 2'd2, 15'd5, 8'h05, "R4 both-ended write");
    req(0, 2'd1, 15'd5, 8'h00, "R7 delayed read a5");
    req(1, 2'd1, 15'd6, 8'h06, "R4 we-ended write");
    req(0, 2'd1, 15'd6, 8'h00, "R7 delayed read a6");
    req(1, 2'd3, 15'd7, 8'h01, "R5 first write a7");
    req(1, 2'd0, 15'd7, 8'h07, "R5 overwrite a7");
    req(0, 2'd0, 15'd7, 8'h00, "R5 read overwritten a7");
    req(1, 2'd1, 15'h7FFF, 8'hA5, "R11 write with injected request", 1, 15'd1, 8'hEE);
    req(0, 2'd0, 15'd1, 8'h00, "R11 injected write ignored");
    req(0, 2'd1, 15'h7FFF, 8'h00, "R11 top address kept");
    req(1, 2'd0, 15'd0, 8'h5A, "R2 zero address write");
    req(0, 2'd0, 15'd0, 8'h00, "R6 zero address read");

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R10 all completions seen", sbq.size(), 0);
    check(v_idle == 0, "R1 idle bus quiet", v_idle, 0);
    check(v_setup == 0, "R2 setup before strobe", v_setup, 0);
    check(v_stable == 0, "R2 address stable", v_stable, 0);
    check(v_contend == 0, "R8 no contention", v_contend, 0);
    check(v_hold == 0, "R9 hold before address change", v_hold, 0);
    check(v_data == 0, "R5 data driven at write end", v_data, 0);
    summary();
    $finish;
  end
endmodule